// File: doc/BRIEF.md
# Bank-Switched UART Configuration Register File

This block is the host side of a 16550-style serial port's register space. A byte-wide bus with separate write and read strobes and a 4-bit offset reaches a small set of configuration registers. The register that an offset selects depends on the value currently held in the line control register. The exact value 0xBF opens the extended bank, where offset 2 reaches the enhanced feature register. Any value with bit 7 set opens the divisor bytes at offsets 0 and 1. A separate mode register at offset 8 starts in a disabled state and must be cleared to 0 before the port runs as a plain UART.

The block drives the configuration that the rest of the port consumes: the baud divisor, the word format fields, the FIFO enable and DMA selection, single-cycle FIFO clear strobes, the enhanced enable and the operating mode. The shifter, the baud generator and the FIFOs are outside this block. A typical bring-up puts the port in disabled mode, selects the 0xBF bank, sets the enhanced bit by read-modify-write, and selects 0x80 to write 0x07 to FIFO control. It then returns to 0xBF, loads divisor 7 (115200 baud from 13 MHz at 16x oversampling), writes 0x03 to line control for 8N1 and finally writes 0 to the mode register.

Top module: `uart_cfg_bank`

## Requirements
- R1: After a synchronous reset: line control 0x00, divisor 0x0000, enhanced feature 0x00, mode 7, `port_active` 0, FIFO enable 0, DMA 0, no clear strobes, `rdata` 0x00.
- R2: Offset 3 reads and writes the full line control byte whatever its current value.
- R3: While line control equals 0xBF, offset 2 reads and writes the 8-bit enhanced feature register, and a write there leaves FIFO enable and DMA unchanged.
- R4: While line control bit 7 is 1 (0x80 and 0xBF included), offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes bits 15:8. `divisor` shows a write on the clock edge that takes it.
- R5: While line control bit 7 is 0, writes to offsets 0 and 1 leave the divisor unchanged, and reads there return 0x00.
- R6: While line control is not 0xBF, a write to offset 2 goes to FIFO control and leaves the enhanced feature register unchanged. A read at offset 2 returns the interrupt ID byte {F,F,000001}, where F is the FIFO enable.
- R7: A FIFO control write stores bit 0 as `fifo_en` and bit 3 as `dma_mode`. Bit 1 raises `rx_fifo_clr` and bit 2 raises `tx_fifo_clr` for exactly the cycle after the write. The strobes are not stored.
- R8: Offset 8 is the 3-bit mode register, read back as {00000,mode}. `op_mode` shows it and `port_active` is 1 only when it is 0. Writes in every mode are accepted.
- R9: `word_len` is line control bits 1:0 (00 gives 5 bits, 11 gives 8 bits), `two_stop` is bit 2, `parity_en` is bit 3 and `parity_even` is bit 4.
- R10: `enh_en` is enhanced feature bit 4. The register reads back all 8 stored bits, so a read-modify-write keeps the other bits.
- R11: Offsets 4 to 7 and 9 to 15 read 0x00, and writes there change no register or output.
- R12: `rdata` is registered. It takes the selected value on the edge that samples `rd_en`, using the bank in force before any write at that edge, and holds on other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| divisor | output | 16 | Baud divisor |
| word_len | output | 2 | Data bits code |
| two_stop | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity enable |
| parity_even | output | 1 | Even parity select |
| fifo_en | output | 1 | FIFOs enabled |
| dma_mode | output | 1 | DMA mode select |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| enh_en | output | 1 | Enhanced functions enabled |
| op_mode | output | 3 | Operating mode register |
| port_active | output | 1 | Mode is plain UART (0) |

## Verification
The enhanced feature register is the hardest state to reach. It answers only while line control holds the one exact value 0xBF, and any other line control write hides it behind FIFO control. The random stimulus therefore picks line control writes mostly from 0x00, 0x03, 0x80 and 0xBF, so the bench moves between banks often and also catches offset 2 writes that land in the wrong bank. A directed pass replays the full bring-up sequence, including the enhanced-bit read-modify-write, and follows it with back-to-back FIFO control writes to check that the clear strobes do not merge.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIV_LO, SEL_DIV_HI, SEL_IIR_FCR, SEL_EFR, SEL_LCR, SEL_MODE
  } reg_sel_e;

  localparam logic [7:0] LCR_EXT_KEY = 8'hBF;
  localparam int LCR_DL_BIT   = 7;
  localparam int FCR_FIFO_BIT = 0;
  localparam int FCR_RXC_BIT  = 1;
  localparam int FCR_TXC_BIT  = 2;
  localparam int FCR_DMA_BIT  = 3;
  localparam int EFR_ENH_BIT  = 4;
  localparam int OFS_DIV_LO   = 0;
  localparam int OFS_DIV_HI   = 1;
  localparam int OFS_SHARED   = 2;
  localparam int OFS_LCR      = 3;
  localparam int OFS_MODE     = 8;
endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_cfg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [7:0]        lcr,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  logic ext_bank;
  logic dl_bank;

  assign ext_bank = (lcr == LCR_EXT_KEY);
  assign dl_bank  = lcr[LCR_DL_BIT];

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFS_DIV_LO))      sel = dl_bank ? SEL_DIV_LO : SEL_NONE;
    else if (addr == ADDR_W'(OFS_DIV_HI)) sel = dl_bank ? SEL_DIV_HI : SEL_NONE;
    else if (addr == ADDR_W'(OFS_SHARED)) sel = ext_bank ? SEL_EFR : SEL_IIR_FCR;
    else if (addr == ADDR_W'(OFS_LCR))    sel = SEL_LCR;
    else if (addr == ADDR_W'(OFS_MODE))   sel = SEL_MODE;
  end
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_cfg_pkg::*;
#(
  parameter int            DATA_W     = 8,
  parameter int            MODE_W     = 3,
  parameter logic [MODE_W-1:0] MODE_RESET = MODE_W'(7)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  reg_sel_e            sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   lcr,
  output logic [DATA_W-1:0]   efr,
  output logic [2*DATA_W-1:0] divisor,
  output logic                fifo_en,
  output logic                dma_mode,
  output logic                rx_clr,
  output logic                tx_clr,
  output logic [MODE_W-1:0]   mode
);
  logic wr_fcr;
  assign wr_fcr = wr_en && (sel == SEL_IIR_FCR);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr      <= '0;
      efr      <= '0;
      divisor  <= '0;
      fifo_en  <= 1'b0;
      dma_mode <= 1'b0;
      rx_clr   <= 1'b0;
      tx_clr   <= 1'b0;
      mode     <= MODE_RESET;
    end else begin
      rx_clr <= wr_fcr && wdata[FCR_RXC_BIT];
      tx_clr <= wr_fcr && wdata[FCR_TXC_BIT];
      if (wr_en) begin
        case (sel)
          SEL_LCR:    lcr <= wdata;
          SEL_EFR:    efr <= wdata;
          SEL_DIV_LO: divisor[DATA_W-1:0] <= wdata;
          SEL_DIV_HI: divisor[2*DATA_W-1:DATA_W] <= wdata;
          SEL_MODE:   mode <= wdata[MODE_W-1:0];
          SEL_IIR_FCR: begin
            fifo_en  <= wdata[FCR_FIFO_BIT];
            dma_mode <= wdata[FCR_DMA_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  // R2: line control moves only on a write to its offset
  p_lcr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == SEL_LCR) |=> $stable(lcr));
  // R3 and R6: enhanced register moves only in its own bank
  p_efr_guard_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == SEL_EFR) |=> $stable(efr));
  // R5: divisor moves only through the divisor offsets
  p_div_guard_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (sel == SEL_DIV_LO || sel == SEL_DIV_HI)) |=> $stable(divisor));
  // R7: a clear strobe always follows a FIFO control write
  p_rxclr_src_r7: assert property (@(posedge clk) disable iff (rst)
    rx_clr |-> $past(wr_en && sel == SEL_IIR_FCR));
  p_txclr_src_r7: assert property (@(posedge clk) disable iff (rst)
    tx_clr |-> $past(wr_en && sel == SEL_IIR_FCR));
  // R8: mode register moves only on a write to offset 8
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == SEL_MODE) |=> $stable(mode));
endmodule

// File: rtl/uart_cfg_bank.sv
module uart_cfg_bank
  import uart_cfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [15:0]       divisor,
  output logic [1:0]        word_len,
  output logic              two_stop,
  output logic              parity_en,
  output logic              parity_even,
  output logic              fifo_en,
  output logic              dma_mode,
  output logic              rx_fifo_clr,
  output logic              tx_fifo_clr,
  output logic              enh_en,
  output logic [MODE_W-1:0] op_mode,
  output logic              port_active
);
  localparam int DATA_W = 8;

  reg_sel_e    sel;
  logic [7:0]  lcr;
  logic [7:0]  efr;
  logic [7:0]  iir;
  logic [7:0]  rd_mux;

  uart_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .lcr  (lcr),
    .addr (addr),
    .sel  (sel)
  );

  uart_cfg_regs #(.DATA_W(DATA_W), .MODE_W(MODE_W), .MODE_RESET(MODE_W'(7))) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .sel      (sel),
    .wdata    (wdata),
    .lcr      (lcr),
    .efr      (efr),
    .divisor  (divisor),
    .fifo_en  (fifo_en),
    .dma_mode (dma_mode),
    .rx_clr   (rx_fifo_clr),
    .tx_clr   (tx_fifo_clr),
    .mode     (op_mode)
  );

  assign iir = {fifo_en, fifo_en, 6'b000001};

  always_comb begin
    case (sel)
      SEL_DIV_LO:  rd_mux = divisor[7:0];
      SEL_DIV_HI:  rd_mux = divisor[15:8];
      SEL_IIR_FCR: rd_mux = iir;
      SEL_EFR:     rd_mux = efr;
      SEL_LCR:     rd_mux = lcr;
      SEL_MODE:    rd_mux = 8'(op_mode);
      default:     rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
  end

  assign word_len    = lcr[1:0];
  assign two_stop    = lcr[2];
  assign parity_en   = lcr[3];
  assign parity_even = lcr[4];
  assign enh_en      = efr[EFR_ENH_BIT];
  assign port_active = (op_mode == '0);

  // R12: read data holds when no read is strobed
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  // R11: unmapped offsets always return zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_NONE) |=> rdata == 8'h00);
endmodule

// File: tb/uart_cfg_bank_test.sv
module uart_cfg_bank_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst, wr_en, rd_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [15:0] divisor;
  logic [1:0] word_len;
  logic two_stop, parity_en, parity_even, fifo_en, dma_mode;
  logic rx_fifo_clr, tx_fifo_clr, enh_en, port_active;
  logic [2:0] op_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  m_lcr, m_efr, m_rd;
  logic [15:0] m_div;
  logic        m_fen, m_dma, m_rxc, m_txc;
  logic [2:0]  m_mode;

  always #(CLK_P/2) clk = ~clk;

  uart_cfg_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .divisor(divisor), .word_len(word_len),
    .two_stop(two_stop), .parity_en(parity_en), .parity_even(parity_even),
    .fifo_en(fifo_en), .dma_mode(dma_mode), .rx_fifo_clr(rx_fifo_clr),
    .tx_fifo_clr(tx_fifo_clr), .enh_en(enh_en), .op_mode(op_mode),
    .port_active(port_active)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return m_lcr[7] ? m_div[7:0]  : 8'h00;
      4'd1: return m_lcr[7] ? m_div[15:8] : 8'h00;
      4'd2: return (m_lcr == 8'hBF) ? m_efr : {m_fen, m_fen, 6'b000001};
      4'd3: return m_lcr;
      4'd8: return {5'b0, m_mode};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [3:0] a);
    case (a)
      4'd0, 4'd1: return m_lcr[7] ? "R4" : "R5";
      4'd2: return (m_lcr == 8'hBF) ? "R3" : "R6";
      4'd3: return "R2";
      4'd8: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    case (a)
      4'd0: if (m_lcr[7]) m_div[7:0] = d;
      4'd1: if (m_lcr[7]) m_div[15:8] = d;
      4'd2: if (m_lcr == 8'hBF) m_efr = d;
            else begin m_fen = d[0]; m_dma = d[3]; m_rxc = d[1]; m_txc = d[2]; end
      4'd3: m_lcr = d;
      4'd8: m_mode = d[2:0];
      default: ;
    endcase
  endtask

  task automatic compare_all();
    chk(divisor == m_div, "R4", divisor, m_div);
    chk({word_len, two_stop, parity_en, parity_even} == {m_lcr[1:0], m_lcr[2], m_lcr[3], m_lcr[4]},
        "R9", 16'({word_len, two_stop, parity_en, parity_even}),
        16'({m_lcr[1:0], m_lcr[2], m_lcr[3], m_lcr[4]}));
    chk({fifo_en, dma_mode} == {m_fen, m_dma}, "R7", 16'({fifo_en, dma_mode}), 16'({m_fen, m_dma}));
    chk({rx_fifo_clr, tx_fifo_clr} == {m_rxc, m_txc}, "R7", 16'({rx_fifo_clr, tx_fifo_clr}), 16'({m_rxc, m_txc}));
    chk(enh_en == m_efr[4], "R10", 16'(enh_en), 16'(m_efr[4]));
    chk(op_mode == m_mode && port_active == (m_mode == 3'd0), "R8",
        16'({op_mode, port_active}), 16'({m_mode, m_mode == 3'd0}));
    chk(rdata == m_rd, "R12", 16'(rdata), 16'(m_rd));
  endtask

  task automatic step(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d);
    logic [7:0] rexp;
    string tg;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    rexp = model_read(a);
    tg = read_tag(a);
    @(posedge clk);
    #1;
    m_rxc = 1'b0; m_txc = 1'b0;
    if (r) begin
      m_rd = rexp;
      chk(rdata == rexp, tg, 16'(rdata), 16'(rexp));
    end
    if (w) model_write(a, d);
    wr_en = 1'b0; rd_en = 1'b0;
    compare_all();
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d); step(1'b1, 1'b0, a, d); endtask
  task automatic rd(input logic [3:0] a); step(1'b0, 1'b1, a, 8'h00); endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] tmp;
    rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    m_lcr = 0; m_efr = 0; m_div = 0; m_fen = 0; m_dma = 0; m_rxc = 0; m_txc = 0;
    m_mode = 3'd7; m_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    chk(divisor == 16'h0000 && op_mode == 3'd7 && !port_active && !fifo_en && !dma_mode
        && !enh_en && !rx_fifo_clr && !tx_fifo_clr && rdata == 8'h00 && word_len == 2'b00,
        "R1", {divisor[11:0], 1'b0, op_mode}, 16'h0007);
    rd(4'd3);
    chk(rdata == 8'h00, "R1", 16'(rdata), 16'h0000);

    // bring-up sequence
    wr(4'd8, 8'h07);
    wr(4'd3, 8'hBF);
    wr(4'd2, 8'h25);          // R3: preload other EFR bits
    rd(4'd2);
    tmp = rdata | 8'h10;
    wr(4'd2, tmp);
    chk(enh_en == 1'b1, "R10", 16'(enh_en), 16'h1);
    rd(4'd2);
    chk(rdata == 8'h35, "R10", 16'(rdata), 16'h35);
    wr(4'd3, 8'h80);
    wr(4'd2, 8'h07);          // R7 pulses checked by compare_all
    chk(fifo_en && !dma_mode, "R7", 16'({fifo_en, dma_mode}), 16'b10);
    rd(4'd2);
    chk(rdata == 8'hC1, "R6", 16'(rdata), 16'hC1);
    wr(4'd3, 8'hBF);
    wr(4'd0, 8'h07);
    wr(4'd1, 8'h00);
    chk(divisor == 16'h0007, "R4", divisor, 16'h0007);
    wr(4'd3, 8'h03);
    chk(word_len == 2'b11 && !two_stop && !parity_en, "R9", 16'({word_len, two_stop, parity_en}), 16'b1100);
    wr(4'd8, 8'h00);
    chk(port_active, "R8", 16'(port_active), 16'h1);

    // R5: normal bank ignores divisor offsets
    wr(4'd0, 8'hAA);
    wr(4'd1, 8'h55);
    chk(divisor == 16'h0007, "R5", divisor, 16'h0007);
    rd(4'd0);
    chk(rdata == 8'h00, "R5", 16'(rdata), 16'h0000);
    // R6: FCR write outside 0xBF leaves EFR
    wr(4'd2, 8'h0E);
    chk(enh_en == 1'b1 && dma_mode && !fifo_en, "R6", 16'({enh_en, dma_mode, fifo_en}), 16'b110);
    // R7: back-to-back clear strobes
    wr(4'd2, 8'h02);
    wr(4'd2, 8'h04);
    step(1'b0, 1'b0, 4'd0, 8'h00);
    chk(!rx_fifo_clr && !tx_fifo_clr, "R7", 16'({rx_fifo_clr, tx_fifo_clr}), 16'h0);
    // R11: unmapped offsets
    for (int a = 4; a < 16; a++) begin
      if (a == 8) continue;
      wr(4'(a), 8'hFF);
      rd(4'(a));
    end
    rd(4'd3);
    chk(rdata == 8'h03 && divisor == 16'h0007, "R11", {rdata, divisor[7:0]}, 16'h0307);
    // R12: read in same cycle as LCR write uses old bank
    step(1'b1, 1'b1, 4'd3, 8'h80);
    chk(rdata == 8'h03, "R12", 16'(rdata), 16'h03);
    // R2: LCR readable in every bank
    wr(4'd3, 8'hBF); rd(4'd3);
    chk(rdata == 8'hBF, "R2", 16'(rdata), 16'hBF);

    // random phase
    void'($urandom(32'd20240501));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      int pick;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0, 1: a = 4'd3;
        2, 3: a = 4'd2;
        4:    a = 4'd0;
        5:    a = 4'd1;
        6:    a = 4'd8;
        default: a = 4'($urandom_range(0, 15));
      endcase
      d = 8'($urandom);
      if (a == 4'd3) begin
        case ($urandom_range(0, 4))
          0: d = 8'h00;
          1: d = 8'h03;
          2: d = 8'h80;
          3: d = 8'hBF;
          default: ;
        endcase
      end
      step(1'($urandom), 1'($urandom), a, d);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule